// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block is the instruction buffer that sits between dispatch and a group of identical execution units. Each accepted instruction carries a result tag, two source tags with their readiness bits and an execution latency. An entry stays in the buffer while it waits for its operands. Result tags that are broadcast on the wake-up bus, or that the buffer itself writes back, make waiting entries ready. Ready entries issue to the units with the oldest first. The buffer then keeps each issued entry until its latency has run out. At that point the entry reports write-back, leaves the buffer, and its tag wakes the entries that depend on it.

Dispatch is a valid/ready stream. A transfer happens on a clock edge where `disp_valid` and `disp_ready` are both high. `disp_ready` drops only when every slot is occupied, and it never depends on `disp_valid`. While `disp_ready` is low, the source may hold or change its request; nothing is taken. The issue and write-back outputs carry no ready signal, because the units and the retire logic accept every grant the moment it is shown. The wake-up bus is a plain one-cycle strobe. Occupancy, the peak occupancy and a histogram of issues per cycle are plain status outputs.

Top module: `oo_issue_sched`

## Requirements
- R1: `disp_ready` is low exactly when DEPTH entries are occupied, and `full` is then high. `occ` equals the number of occupied entries. It rises by one for each accepted dispatch and falls by one for each write-back.
- R2: A newly accepted entry starts in the ready state when each source either has its ready bit set or has a tag equal to a wake-up tag (broadcast or write-back) active in the same cycle. Otherwise it starts waiting.
- R3: A waiting entry records a source as ready when that source's tag matches an active wake-up tag. Once both sources are ready, it can issue no earlier than the next cycle.
- R4: An entry can issue no earlier than the cycle after its dispatch. Up to NUM_UNITS ready entries issue per cycle, the oldest first. Issue lane r carries the r-th oldest of the entries that issue, so valid lanes are always the lowest ones.
- R5: The unit on lane r is (p + r) mod NUM_UNITS. p starts at 0 after reset and advances by the number of issues in each cycle, modulo NUM_UNITS.
- R6: An entry issued in cycle c with latency L becomes eligible for write-back in cycle c+L, where a latency of 0 counts as 1. One write-back is shown per cycle, taking the oldest eligible entry. Eligible entries that are not chosen wait. The chosen entry leaves the buffer at the end of that cycle.
- R7: With a write-back the block reports two counts. The first is the cycles the entry spent in the buffer, equal to the write-back cycle minus the dispatch cycle. The second is the cycles in which it was ready but not issued. Both counts saturate at their maximum value.
- R8: `occ_max` is the largest occupancy seen since reset. It includes the current cycle's occupancy from the next cycle on.
- R9: Histogram counter k rises by one at every clock edge where exactly k instructions issue. Each counter saturates at its maximum value.
- R10: During reset the buffer is empty. No issue or write-back is shown, and `full`, `occ`, `occ_max` and all histogram counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | Buffer can take a dispatch |
| disp_tag | input | TAG_W | Result tag of the dispatched instruction |
| disp_srca_tag | input | TAG_W | Tag of the first source |
| disp_srca_rdy | input | 1 | First source already available |
| disp_srcb_tag | input | TAG_W | Tag of the second source |
| disp_srcb_rdy | input | 1 | Second source already available |
| disp_lat | input | LAT_W | Execution latency in cycles (0 acts as 1) |
| bcast_valid | input | 1 | External wake-up strobe |
| bcast_tag | input | TAG_W | External wake-up tag |
| iss_valid | output | NUM_UNITS | Per-lane issue grant |
| iss_tag | output | NUM_UNITS x TAG_W | Tag issued on each lane |
| iss_unit | output | NUM_UNITS x UNIT_W | Unit chosen for each lane |
| wb_valid | output | 1 | Write-back notification |
| wb_tag | output | TAG_W | Tag written back |
| wb_buf_cyc | output | CNT_W | Cycles the entry spent in the buffer |
| wb_rdy_wait | output | CNT_W | Cycles the entry waited while ready |
| full | output | 1 | All entries occupied |
| occ | output | OCC_W | Current occupancy |
| occ_max | output | OCC_W | Peak occupancy since reset |
| iss_hist | output | (NUM_UNITS+1) x HIST_W | Cycles with k issues, index k |

## Verification
The issue grants and write-back notifications are combinational views of the registered entry state. An entry dispatched at edge t can therefore appear on an issue lane in the cycle right after t, at the earliest. An entry that issues in cycle c can write back in cycle c+L. A wake-up seen in cycle w allows issue in cycle w+1. `occ` follows a dispatch or write-back by one edge. `occ_max` and the histogram lag by one further edge. The bench drives inputs just after the falling edge and keeps a behavioural queue model that predicts every output of the current cycle. It compares them before the next rising edge, and only then advances the model by one edge.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2
  } ent_state_e;
endpackage

// File: rtl/sched_age_rank.sv
// For every slot, counts requesting slots that are older than it.
// older[i][j] is set when slot j entered the buffer before slot i.
module sched_age_rank #(
  parameter int N  = 8,
  parameter int RW = 4
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][N-1:0]  older,
  output logic [N-1:0][RW-1:0] rank
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        rank[i] = rank[i] + RW'(req[j] & older[i][j]);
      end
    end
  end
endmodule

// File: rtl/sched_rr_unit.sv
// Rotating start point for unit selection inside the group.
module sched_rr_unit #(
  parameter int NU = 2,
  parameter int UW = 1,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] n_iss,
  output logic [UW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= UW'((int'(ptr) + int'(n_iss)) % NU);
  end
endmodule

// File: rtl/sched_stats.sv
// Peak occupancy and a saturating issues-per-cycle histogram.
module sched_stats #(
  parameter int NU = 2,
  parameter int OW = 4,
  parameter int HW = 16,
  parameter int CW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OW-1:0]      occ,
  input  logic [CW-1:0]      n_iss,
  output logic [OW-1:0]      occ_max,
  output logic [NU:0][HW-1:0] hist
);
  logic [HW-1:0] bin [NU+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             occ_max <= '0;
    else if (occ > occ_max) occ_max <= occ;
  end

  for (genvar k = 0; k <= NU; k++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 bin[k] <= '0;
      else if (int'(n_iss) == k && bin[k] != '1)  bin[k] <= bin[k] + HW'(1);
    end
    assign hist[k] = bin[k];
  end
endmodule

// File: rtl/oo_issue_sched.sv
module oo_issue_sched
  import sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_UNITS = 2,
  parameter int TAG_W     = 4,
  parameter int LAT_W     = 4,
  parameter int CNT_W     = 8,
  parameter int HIST_W    = 16,
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int ISS_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              disp_valid,
  output logic                              disp_ready,
  input  logic [TAG_W-1:0]                  disp_tag,
  input  logic [TAG_W-1:0]                  disp_srca_tag,
  input  logic                              disp_srca_rdy,
  input  logic [TAG_W-1:0]                  disp_srcb_tag,
  input  logic                              disp_srcb_rdy,
  input  logic [LAT_W-1:0]                  disp_lat,
  input  logic                              bcast_valid,
  input  logic [TAG_W-1:0]                  bcast_tag,
  output logic [NUM_UNITS-1:0]              iss_valid,
  output logic [NUM_UNITS-1:0][TAG_W-1:0]   iss_tag,
  output logic [NUM_UNITS-1:0][UNIT_W-1:0]  iss_unit,
  output logic                              wb_valid,
  output logic [TAG_W-1:0]                  wb_tag,
  output logic [CNT_W-1:0]                  wb_buf_cyc,
  output logic [CNT_W-1:0]                  wb_rdy_wait,
  output logic                              full,
  output logic [OCC_W-1:0]                  occ,
  output logic [OCC_W-1:0]                  occ_max,
  output logic [NUM_UNITS:0][HIST_W-1:0]    iss_hist
);
  localparam int RANK_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             v;
  ent_state_e                   st     [DEPTH];
  logic [TAG_W-1:0]             e_tag  [DEPTH];
  logic [TAG_W-1:0]             e_sa   [DEPTH];
  logic [TAG_W-1:0]             e_sb   [DEPTH];
  logic [DEPTH-1:0]             e_ra, e_rb;
  logic [LAT_W-1:0]             e_lat  [DEPTH];
  logic [LAT_W-1:0]             e_cnt  [DEPTH];
  logic [CNT_W-1:0]             e_tbuf [DEPTH];
  logic [CNT_W-1:0]             e_trdy [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0]  older;

  logic [DEPTH-1:0]             rdy_vec, done_vec, iss_vec, wb_vec, alloc_vec;
  logic [DEPTH-1:0][RANK_W-1:0] iss_rank, wb_rank;
  logic [UNIT_W-1:0]            rr_ptr;
  logic [ISS_W-1:0]             n_iss;
  logic                         accept;

  function automatic logic woken(input logic [TAG_W-1:0] t);
    return (bcast_valid && bcast_tag == t) || (wb_valid && wb_tag == t);
  endfunction

  // Capacity, occupancy, free-slot choice
  always_comb begin
    logic found;
    full       = &v;
    disp_ready = ~full;
    accept     = disp_valid && !full;
    occ        = '0;
    alloc_vec  = '0;
    found      = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      occ = occ + OCC_W'(v[i]);
      if (!v[i] && !found) begin
        alloc_vec[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdy_vec[i]  = v[i] && st[i] == ST_READY;
      done_vec[i] = v[i] && st[i] == ST_EXEC && e_cnt[i] == '0;
    end
  end

  sched_age_rank #(.N(DEPTH), .RW(RANK_W)) u_iss_rank (
    .req(rdy_vec), .older(older), .rank(iss_rank)
  );
  sched_age_rank #(.N(DEPTH), .RW(RANK_W)) u_wb_rank (
    .req(done_vec), .older(older), .rank(wb_rank)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      iss_vec[i] = rdy_vec[i] && int'(iss_rank[i]) < NUM_UNITS;
      wb_vec[i]  = done_vec[i] && wb_rank[i] == '0;
    end
  end

  // Issue lanes: lane r takes the entry with r older issuing entries
  always_comb begin
    iss_valid = '0;
    iss_tag   = '0;
    iss_unit  = '0;
    n_iss     = '0;
    for (int r = 0; r < NUM_UNITS; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (iss_vec[i] && int'(iss_rank[i]) == r) begin
          iss_valid[r] = 1'b1;
          iss_tag[r]   = e_tag[i];
          iss_unit[r]  = UNIT_W'((int'(rr_ptr) + r) % NUM_UNITS);
          n_iss        = n_iss + ISS_W'(1);
        end
      end
    end
  end

  always_comb begin
    wb_valid    = |wb_vec;
    wb_tag      = '0;
    wb_buf_cyc  = '0;
    wb_rdy_wait = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wb_vec[i]) begin
        wb_tag      = e_tag[i];
        wb_buf_cyc  = e_tbuf[i];
        wb_rdy_wait = e_trdy[i];
      end
    end
  end

  // Entry state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v     <= '0;
      older <= '0;
      e_ra  <= '0;
      e_rb  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st[i]     <= ST_WAIT;
        e_tag[i]  <= '0;
        e_sa[i]   <= '0;
        e_sb[i]   <= '0;
        e_lat[i]  <= '0;
        e_cnt[i]  <= '0;
        e_tbuf[i] <= '0;
        e_trdy[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && alloc_vec[i]) begin
          v[i]      <= 1'b1;
          e_tag[i]  <= disp_tag;
          e_sa[i]   <= disp_srca_tag;
          e_sb[i]   <= disp_srcb_tag;
          e_ra[i]   <= disp_srca_rdy || woken(disp_srca_tag);
          e_rb[i]   <= disp_srcb_rdy || woken(disp_srcb_tag);
          st[i]     <= ((disp_srca_rdy || woken(disp_srca_tag)) &&
                        (disp_srcb_rdy || woken(disp_srcb_tag))) ? ST_READY : ST_WAIT;
          e_lat[i]  <= disp_lat;
          e_cnt[i]  <= '0;
          e_tbuf[i] <= CNT_W'(1);
          e_trdy[i] <= '0;
          for (int j = 0; j < DEPTH; j++) begin
            older[j][i] <= 1'b0;
            older[i][j] <= v[j];
          end
        end else if (v[i]) begin
          if (e_tbuf[i] != '1) e_tbuf[i] <= e_tbuf[i] + CNT_W'(1);
          case (st[i])
            ST_WAIT: begin
              e_ra[i] <= e_ra[i] || woken(e_sa[i]);
              e_rb[i] <= e_rb[i] || woken(e_sb[i]);
              if ((e_ra[i] || woken(e_sa[i])) && (e_rb[i] || woken(e_sb[i])))
                st[i] <= ST_READY;
            end
            ST_READY: begin
              if (iss_vec[i]) begin
                st[i]    <= ST_EXEC;
                e_cnt[i] <= (e_lat[i] == '0) ? '0 : e_lat[i] - LAT_W'(1);
              end else if (e_trdy[i] != '1) begin
                e_trdy[i] <= e_trdy[i] + CNT_W'(1);
              end
            end
            default: begin
              if (e_cnt[i] != '0) e_cnt[i] <= e_cnt[i] - LAT_W'(1);
              if (wb_vec[i])      v[i]     <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  sched_rr_unit #(.NU(NUM_UNITS), .UW(UNIT_W), .CW(ISS_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .n_iss(n_iss), .ptr(rr_ptr)
  );

  sched_stats #(.NU(NUM_UNITS), .OW(OCC_W), .HW(HIST_W), .CW(ISS_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .occ(occ), .n_iss(n_iss),
    .occ_max(occ_max), .hist(iss_hist)
  );
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int DEPTH     = 8,
  parameter int NUM_UNITS = 2,
  parameter int CNT_W     = 8,
  parameter int OCC_W     = 4,
  parameter int UNIT_W    = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             disp_valid,
  input logic                             disp_ready,
  input logic                             full,
  input logic [OCC_W-1:0]                 occ,
  input logic [OCC_W-1:0]                 occ_max,
  input logic [NUM_UNITS-1:0]             iss_valid,
  input logic [NUM_UNITS-1:0][UNIT_W-1:0] iss_unit,
  input logic                             wb_valid,
  input logic [CNT_W-1:0]                 wb_buf_cyc,
  input logic [CNT_W-1:0]                 wb_rdy_wait
);
  logic [NUM_UNITS-1:0] umask;
  always_comb begin
    umask = '0;
    for (int r = 0; r < NUM_UNITS; r++)
      if (iss_valid[r]) umask[iss_unit[r]] = 1'b1;
  end

  a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  a_r1_full_depth: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> int'(occ) == DEPTH);

  a_r1_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(occ) == int'($past(occ)) + int'($past(disp_valid && disp_ready))
                                  - int'($past(wb_valid)));

  for (genvar r = 1; r < NUM_UNITS; r++) begin : g_lane
    a_r4_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[r] |-> iss_valid[r-1]);
  end

  a_r5_units_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(umask) == $countones(iss_valid));

  a_r6_wb_min_stay: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_buf_cyc >= CNT_W'(2));

  a_r7_rdy_le_buf: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_rdy_wait <= wb_buf_cyc);

  a_r8_max_mono: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (occ_max >= $past(occ_max) && occ_max >= $past(occ)));
endmodule

bind oo_issue_sched sched_checker #(
  .DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS), .CNT_W(CNT_W), .OCC_W(OCC_W), .UNIT_W(UNIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .full(full), .occ(occ), .occ_max(occ_max), .iss_valid(iss_valid),
  .iss_unit(iss_unit), .wb_valid(wb_valid), .wb_buf_cyc(wb_buf_cyc),
  .wb_rdy_wait(wb_rdy_wait)
);

// File: tb/sim_oo_issue_sched.sv
module sim_oo_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int NU     = 2;
  localparam int TAG_W  = 4;
  localparam int LAT_W  = 4;
  localparam int CNT_W  = 8;
  localparam int HIST_W = 16;
  localparam int OCC_W  = 4;
  localparam int UNIT_W = 1;
  localparam int CMAX   = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [TAG_W-1:0] disp_tag = '0, disp_srca_tag = '0, disp_srcb_tag = '0;
  logic disp_srca_rdy = 1'b0, disp_srcb_rdy = 1'b0;
  logic [LAT_W-1:0] disp_lat = '0;
  logic bcast_valid = 1'b0;
  logic [TAG_W-1:0] bcast_tag = '0;
  logic [NU-1:0] iss_valid;
  logic [NU-1:0][TAG_W-1:0] iss_tag;
  logic [NU-1:0][UNIT_W-1:0] iss_unit;
  logic wb_valid;
  logic [TAG_W-1:0] wb_tag;
  logic [CNT_W-1:0] wb_buf_cyc, wb_rdy_wait;
  logic full;
  logic [OCC_W-1:0] occ, occ_max;
  logic [NU:0][HIST_W-1:0] iss_hist;

  oo_issue_sched #(.DEPTH(DEPTH), .NUM_UNITS(NU), .TAG_W(TAG_W), .LAT_W(LAT_W),
                   .CNT_W(CNT_W), .HIST_W(HIST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .disp_srca_tag(disp_srca_tag), .disp_srca_rdy(disp_srca_rdy),
    .disp_srcb_tag(disp_srcb_tag), .disp_srcb_rdy(disp_srcb_rdy), .disp_lat(disp_lat),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .iss_valid(iss_valid),
    .iss_tag(iss_tag), .iss_unit(iss_unit), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_buf_cyc(wb_buf_cyc), .wb_rdy_wait(wb_rdy_wait), .full(full), .occ(occ),
    .occ_max(occ_max), .iss_hist(iss_hist)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: entries kept in age order, st 0 wait / 1 ready / 2 executing
  typedef struct {
    int tag; int sa; int sb; bit ra; bit rb;
    int st; int lat; int cnt; int tbuf; int trdy;
  } ment_t;
  ment_t q[$];
  int rr = 0, occmax = 0;
  int hist [NU+1];
  int n_cmp = 0, n_bad = 0;
  bit saw_full = 1'b0;

  task automatic chk(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic cycle(bit dv, int dtag, int sa, bit ra, int sb, bit rb, int lat,
                       bit bv, int btag);
    int lanes[$];
    int wbi, wtag, nrdy;
    bit e_full, acc;
    ment_t n;
    disp_valid = dv; disp_tag = TAG_W'(dtag);
    disp_srca_tag = TAG_W'(sa); disp_srca_rdy = ra;
    disp_srcb_tag = TAG_W'(sb); disp_srcb_rdy = rb;
    disp_lat = LAT_W'(lat); bcast_valid = bv; bcast_tag = TAG_W'(btag);
    #1;
    e_full = (q.size() == DEPTH);
    if (e_full) saw_full = 1'b1;
    foreach (q[i]) if (q[i].st == 1 && lanes.size() < NU) lanes.push_back(i);
    wbi = -1;
    foreach (q[i]) if (wbi < 0 && q[i].st == 2 && q[i].cnt == 0) wbi = i;

    chk("R1", "full", int'(full), int'(e_full));
    chk("R1", "disp_ready", int'(disp_ready), int'(!e_full));
    chk("R1", "occ", int'(occ), q.size());
    chk("R8", "occ_max", int'(occ_max), occmax);
    for (int r = 0; r < NU; r++) begin
      chk("R2 R3 R4", "iss_valid", int'(iss_valid[r]), int'(r < lanes.size()));
      if (r < lanes.size() && iss_valid[r]) begin
        chk("R4", "iss_tag", int'(iss_tag[r]), q[lanes[r]].tag);
        chk("R5", "iss_unit", int'(iss_unit[r]), (rr + r) % NU);
      end
    end
    chk("R6", "wb_valid", int'(wb_valid), int'(wbi >= 0));
    if (wbi >= 0 && wb_valid) begin
      chk("R6", "wb_tag", int'(wb_tag), q[wbi].tag);
      chk("R7", "wb_buf_cyc", int'(wb_buf_cyc), q[wbi].tbuf);
      chk("R7", "wb_rdy_wait", int'(wb_rdy_wait), q[wbi].trdy);
    end
    for (int k = 0; k <= NU; k++) chk("R9", "iss_hist", int'(iss_hist[k]), hist[k]);

    // advance the model by one rising edge
    hist[lanes.size()]++;
    if (q.size() > occmax) occmax = q.size();
    rr = (rr + lanes.size()) % NU;
    acc  = dv && !e_full;
    wtag = (wbi >= 0) ? q[wbi].tag : -1;
    nrdy = 0;
    foreach (q[i]) begin
      if (q[i].tbuf < CMAX) q[i].tbuf++;
      if (q[i].st == 0) begin
        q[i].ra = q[i].ra || (bv && btag == q[i].sa) || (q[i].sa == wtag);
        q[i].rb = q[i].rb || (bv && btag == q[i].sb) || (q[i].sb == wtag);
        if (q[i].ra && q[i].rb) q[i].st = 1;
      end else if (q[i].st == 1) begin
        if (nrdy < NU) begin
          q[i].st  = 2;
          q[i].cnt = (q[i].lat == 0) ? 0 : q[i].lat - 1;
        end else if (q[i].trdy < CMAX) q[i].trdy++;
        nrdy++;
      end else if (q[i].cnt > 0) q[i].cnt--;
    end
    if (wbi >= 0) q.delete(wbi);
    if (acc) begin
      n.tag = dtag; n.sa = sa; n.sb = sb; n.lat = lat;
      n.ra = ra || (bv && btag == sa) || (sa == wtag);
      n.rb = rb || (bv && btag == sb) || (sb == wtag);
      n.st = (n.ra && n.rb) ? 1 : 0;
      n.cnt = 0; n.tbuf = 1; n.trdy = 0;
      q.push_back(n);
    end
    @(negedge clk);
  endtask

  initial begin
    foreach (hist[k]) hist[k] = 0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    chk("R10", "occ", int'(occ), 0);
    chk("R10", "full", int'(full), 0);
    chk("R10", "iss_valid", int'(iss_valid), 0);
    chk("R10", "wb_valid", int'(wb_valid), 0);
    chk("R10", "occ_max", int'(occ_max), 0);
    for (int k = 0; k <= NU; k++) chk("R10", "iss_hist", int'(iss_hist[k]), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // operands ready at dispatch: oldest-first issue, unit rotation, latencies
    for (int c = 0; c < 60; c++)
      cycle(1'b1, c % 16, 0, 1'b1, 0, 1'b1, 1 + $urandom_range(0, 3), 1'b0, 0);
    // waiting entries on an unbroadcast tag fill the buffer; held request while full
    for (int c = 0; c < 20; c++)
      cycle(1'b1, c % 8, 15, 1'b0, 3, 1'b1, 2, 1'b0, 0);
    chk("R1", "buffer reached full", int'(saw_full), 1);
    // broadcast the missing tag: waiting entries wake and drain
    for (int c = 0; c < 12; c++)
      cycle(1'b1, 9, 0, 1'b1, 0, 1'b1, 0, 1'b1, 15);
    // random traffic
    for (int c = 0; c < 3000; c++)
      cycle($urandom_range(0, 9) < 7, $urandom_range(0, 15),
            $urandom_range(0, 15), $urandom_range(0, 1) == 1,
            $urandom_range(0, 15), $urandom_range(0, 1) == 1,
            $urandom_range(0, 6), $urandom_range(0, 9) < 4, $urandom_range(0, 15));
    // drain with sweeping broadcasts
    for (int c = 0; c < 64; c++)
      cycle(1'b0, 0, 0, 1'b0, 0, 1'b0, 1, 1'b1, c % 16);
    chk("R6", "empty after drain", q.size(), 0);
    chk("R1", "occ after drain", int'(occ), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule